// File: doc/BRIEF.md
# Flash Status Register Protection Logic

This block holds the status and protection word of a serial flash device and decides, for every decoded command strobe, whether the request is granted or refused. It keeps a busy flag and a write-enable latch, along with five block-protect bits, two protect-mode bits and a quad-enable bit. Its inputs are the write-enable, write-disable, write-status, program, erase and chip-erase strobes, the level of the write-protect pin, a power-cycle event and a completion pulse from the array timer. The command shifter, the array and its timing sit outside the block.

A status write is governed by one of four protection modes. The mode comes from the two protect-mode bits, and in one mode also from the write-protect pin. A granted status write, program or erase holds the busy flag until the external done pulse arrives. A new status value takes effect only when that write completes. The state machine has four states: `ST_IDLE`, `ST_WRSR_BUSY`, `ST_PROG_BUSY` and `ST_ERASE_BUSY`.

The transitions are as follows. A granted status write moves `ST_IDLE` to `ST_WRSR_BUSY`. A granted program moves `ST_IDLE` to `ST_PROG_BUSY`. A granted erase or chip erase moves `ST_IDLE` to `ST_ERASE_BUSY`. Any busy state returns to `ST_IDLE` on the done pulse or on a power cycle.

Top module: `fsr_protect`

## Requirements
- R1: After reset the status word is 0x0000, the state is `ST_IDLE`, and neither grant nor reject is asserted.
- R2: The status bits are laid out as follows: bit 0 is busy, bit 1 is the write-enable latch, bits 6:2 are block-protect BP4..BP0 (BP0 at bit 2), bit 7 is protect-mode low (SRP0), bit 8 is protect-mode high (SRP1) and bit 9 is quad enable. Bits 15:10 always read 0. Bits 15:10 and 1:0 of the write data are ignored.
- R3: A cycle with at least one strobe produces exactly one one-cycle pulse on either grant or reject at the next clock edge. A cycle with no strobe produces neither. Register changes caused by a strobe become visible at that same edge.
- R4: When idle, write-enable sets the latch and write-disable clears it. Both are granted.
- R5: With the write-enable latch at 0, write-status, program, erase and chip erase are rejected and change nothing.
- R6: In mode 00, a status write with the latch set is granted whatever the write-protect pin level.
- R7: In mode 01, a status write is rejected while the write-protect pin is 0. It is granted with the latch set while the pin is 1.
- R8: In mode 10, every status write is rejected until a power cycle, and the power cycle changes the mode bits to 00. The block-protect and quad-enable bits are kept.
- R9: In mode 11, every status write is rejected, and a power cycle leaves the mode at 11.
- R10: Chip erase is rejected while any of BP2..BP0 (bits 4:2) is 1. It is granted with the latch set when those three bits are 0, even if BP4 or BP3 is set.
- R11: A granted write-status, program or erase sets busy at its edge and keeps it set until a done pulse. At the edge that samples the done pulse, busy and the latch clear, and a pending status value is loaded. A rejected request leaves the latch unchanged. A done pulse while idle has no effect.
- R12: While busy, every strobe, write-enable and write-disable included, is rejected and leaves the status word unchanged.
- R13: A power cycle clears busy and the latch and discards a pending status write. Any strobe in the same cycle is rejected.
- R14: Two or more strobes in one cycle are rejected together and have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; the status word returns to its default |
| cmd_wren | input | 1 | Write-enable strobe |
| cmd_wrdi | input | 1 | Write-disable strobe |
| cmd_wrsr | input | 1 | Write-status strobe |
| cmd_prog | input | 1 | Page-program strobe |
| cmd_erase | input | 1 | Sector or block erase strobe |
| cmd_chip_erase | input | 1 | Chip-erase strobe |
| wrsr_data | input | 16 | New status value for a write-status strobe |
| wp_n | input | 1 | Write-protect pin level |
| power_cycle | input | 1 | One-cycle power-down/power-up event |
| op_done | input | 1 | Completion pulse of the running operation |
| status | output | 16 | Status word |
| grant | output | 1 | Request accepted, one cycle after the strobe |
| reject | output | 1 | Request refused, one cycle after the strobe |

## Verification
The bench goes after the mode boundaries. If a design ignored the pin in mode 01, it would grant a status write with the pin low. If a design forgot the power-cycle release in mode 10, it would stay locked forever. If a design released mode 11 on a power cycle, it would unlock a one-time setting. The bench also covers the timing around busy. A design that loaded a status value when the write was granted, instead of when it completed, would show the new bits early. A design that let write-enable through while busy would set the latch under a running operation. Other cases are chip erase with only the upper protect bits set, simultaneous strobes, a power cycle that cuts off a pending write, and a done pulse while idle. Each of these would show up as a wrong grant or reject, or a wrong status bit, at a known edge.

// File: rtl/fsr_pkg.sv
package fsr_pkg;

    // Strobe positions inside the packed command vector
    localparam int CMD_N      = 6;
    localparam int CMD_WREN   = 0;
    localparam int CMD_WRDI   = 1;
    localparam int CMD_WRSR   = 2;
    localparam int CMD_PROG   = 3;
    localparam int CMD_ERASE  = 4;
    localparam int CMD_CHIP   = 5;

    typedef enum logic [1:0] {
        ST_IDLE       = 2'd0,
        ST_WRSR_BUSY  = 2'd1,
        ST_PROG_BUSY  = 2'd2,
        ST_ERASE_BUSY = 2'd3
    } fsr_state_t;

    // Protection mode: {SRP1, SRP0}
    typedef enum logic [1:0] {
        PM_SOFT   = 2'b00,
        PM_PIN    = 2'b01,
        PM_SUPPLY = 2'b10,
        PM_OTP    = 2'b11
    } prot_mode_t;

endpackage

// File: rtl/fsr_policy.sv
module fsr_policy
    import fsr_pkg::*;
(
    input  logic [1:0] srp,
    input  logic       wp_n,
    output logic       wrsr_ok
);

    prot_mode_t mode;

    always_comb begin
        mode = prot_mode_t'(srp);
        unique case (mode)
            PM_SOFT:   wrsr_ok = 1'b1;
            PM_PIN:    wrsr_ok = wp_n;
            PM_SUPPLY: wrsr_ok = 1'b0;
            PM_OTP:    wrsr_ok = 1'b0;
            default:   wrsr_ok = 1'b0;
        endcase
    end

endmodule

// File: rtl/fsr_req_decode.sv
module fsr_req_decode
    import fsr_pkg::*;
#(
    parameter int BP_W       = 5,
    parameter int CHIP_GUARD = 3
) (
    input  logic [CMD_N-1:0] cmd,
    input  logic             busy,
    input  logic             wel,
    input  logic             wrsr_ok,
    input  logic [BP_W-1:0]  bp,
    input  logic             power_cycle,
    output logic [CMD_N-1:0] acc,
    output logic             rej
);

    logic [CMD_N-1:0] perm;
    logic             guard_clear;
    int               n_req;

    assign guard_clear = (bp[CHIP_GUARD-1:0] == '0);

    always_comb begin
        perm            = '0;
        perm[CMD_WREN]  = 1'b1;
        perm[CMD_WRDI]  = 1'b1;
        perm[CMD_WRSR]  = wel & wrsr_ok;
        perm[CMD_PROG]  = wel;
        perm[CMD_ERASE] = wel;
        perm[CMD_CHIP]  = wel & guard_clear;
    end

    always_comb begin
        n_req = $countones(cmd);
        acc   = '0;
        rej   = 1'b0;
        if (n_req != 0) begin
            if (power_cycle || busy || (n_req > 1)) begin
                rej = 1'b1;
            end else begin
                acc = cmd & perm;
                rej = (acc == '0);
            end
        end
    end

endmodule

// File: rtl/fsr_fsm.sv
module fsr_fsm
    import fsr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go_wrsr,
    input  logic       go_prog,
    input  logic       go_erase,
    input  logic       op_done,
    input  logic       power_cycle,
    output fsr_state_t state,
    output logic       busy,
    output logic       finish,
    output logic       commit_wrsr
);

    fsr_state_t state_nxt;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // Next-state logic
    always_comb begin
        state_nxt = state;
        if (power_cycle) begin
            state_nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (go_wrsr)       state_nxt = ST_WRSR_BUSY;
                    else if (go_prog)  state_nxt = ST_PROG_BUSY;
                    else if (go_erase) state_nxt = ST_ERASE_BUSY;
                end
                ST_WRSR_BUSY, ST_PROG_BUSY, ST_ERASE_BUSY: begin
                    if (op_done) state_nxt = ST_IDLE;
                end
                default: state_nxt = ST_IDLE;
            endcase
        end
    end

    assign busy        = (state != ST_IDLE);
    assign finish      = busy & op_done & ~power_cycle;
    assign commit_wrsr = (state == ST_WRSR_BUSY) & finish;

endmodule

// File: rtl/fsr_protect.sv
module fsr_protect
    import fsr_pkg::*;
#(
    parameter int STATUS_W   = 16,
    parameter int BP_W       = 5,
    parameter int CHIP_GUARD = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_wren,
    input  logic                cmd_wrdi,
    input  logic                cmd_wrsr,
    input  logic                cmd_prog,
    input  logic                cmd_erase,
    input  logic                cmd_chip_erase,
    input  logic [STATUS_W-1:0] wrsr_data,
    input  logic                wp_n,
    input  logic                power_cycle,
    input  logic                op_done,
    output logic [STATUS_W-1:0] status,
    output logic                grant,
    output logic                reject
);

    localparam int WIP_POS  = 0;
    localparam int WEL_POS  = 1;
    localparam int BP_LO    = 2;
    localparam int SRP0_POS = BP_LO + BP_W;
    localparam int SRP1_POS = SRP0_POS + 1;
    localparam int QE_POS   = SRP1_POS + 1;
    localparam int USED_W   = QE_POS + 1;

    logic [CMD_N-1:0]     cmd;
    logic [CMD_N-1:0]     acc;
    logic                 rej;
    logic                 wrsr_ok;
    logic                 busy;
    logic                 finish;
    logic                 commit_wrsr;
    fsr_state_t           state;

    logic                 wel_q;
    logic [BP_W-1:0]      bp_q;
    logic [1:0]           srp_q;
    logic                 qe_q;
    logic [USED_W-1:BP_LO] pend_q;

    always_comb begin
        cmd            = '0;
        cmd[CMD_WREN]  = cmd_wren;
        cmd[CMD_WRDI]  = cmd_wrdi;
        cmd[CMD_WRSR]  = cmd_wrsr;
        cmd[CMD_PROG]  = cmd_prog;
        cmd[CMD_ERASE] = cmd_erase;
        cmd[CMD_CHIP]  = cmd_chip_erase;
    end

    fsr_policy u_policy (
        .srp     (srp_q),
        .wp_n    (wp_n),
        .wrsr_ok (wrsr_ok)
    );

    fsr_req_decode #(
        .BP_W       (BP_W),
        .CHIP_GUARD (CHIP_GUARD)
    ) u_decode (
        .cmd         (cmd),
        .busy        (busy),
        .wel         (wel_q),
        .wrsr_ok     (wrsr_ok),
        .bp          (bp_q),
        .power_cycle (power_cycle),
        .acc         (acc),
        .rej         (rej)
    );

    fsr_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .go_wrsr     (acc[CMD_WRSR]),
        .go_prog     (acc[CMD_PROG]),
        .go_erase    (acc[CMD_ERASE] | acc[CMD_CHIP]),
        .op_done     (op_done),
        .power_cycle (power_cycle),
        .state       (state),
        .busy        (busy),
        .finish      (finish),
        .commit_wrsr (commit_wrsr)
    );

    // Register and response updates
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wel_q  <= 1'b0;
            bp_q   <= '0;
            srp_q  <= 2'b00;
            qe_q   <= 1'b0;
            pend_q <= '0;
            grant  <= 1'b0;
            reject <= 1'b0;
        end else begin
            grant  <= (acc != '0);
            reject <= rej;
            if (power_cycle) begin
                wel_q <= 1'b0;
                if (prot_mode_t'(srp_q) == PM_SUPPLY) srp_q <= 2'b00;
            end else begin
                if (finish) wel_q <= 1'b0;
                if (commit_wrsr) begin
                    bp_q  <= pend_q[SRP0_POS-1:BP_LO];
                    srp_q <= pend_q[SRP1_POS:SRP0_POS];
                    qe_q  <= pend_q[QE_POS];
                end
                if (acc[CMD_WREN]) wel_q <= 1'b1;
                if (acc[CMD_WRDI]) wel_q <= 1'b0;
                if (acc[CMD_WRSR]) pend_q <= wrsr_data[USED_W-1:BP_LO];
            end
        end
    end

    assign status[WIP_POS]           = busy;
    assign status[WEL_POS]           = wel_q;
    assign status[SRP0_POS-1:BP_LO]  = bp_q;
    assign status[SRP0_POS]          = srp_q[0];
    assign status[SRP1_POS]          = srp_q[1];
    assign status[QE_POS]            = qe_q;

    generate
        for (genvar gi = USED_W; gi < STATUS_W; gi++) begin : g_rsvd
            assign status[gi] = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/fsr_protect_chk.sv
module fsr_protect_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cmd_wren,
    input logic        cmd_wrdi,
    input logic        cmd_wrsr,
    input logic        cmd_prog,
    input logic        cmd_erase,
    input logic        cmd_chip_erase,
    input logic        power_cycle,
    input logic        op_done,
    input logic [15:0] status,
    input logic        grant,
    input logic        reject
);

    logic any_cmd;
    logic wr_cmd;
    assign any_cmd = cmd_wren | cmd_wrdi | cmd_wrsr | cmd_prog | cmd_erase | cmd_chip_erase;
    assign wr_cmd  = cmd_wrsr | cmd_prog | cmd_erase | cmd_chip_erase;

    assert_rsvd_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        status[15:10] == 6'd0);

    assert_one_response_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(grant && reject));

    assert_response_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
        any_cmd |=> (grant || reject));

    assert_no_wel_reject_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!status[1] && wr_cmd) |=> reject);

    assert_otp_reject_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (status[8] && status[7] && cmd_wrsr) |=> reject);

    assert_otp_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (status[8] && status[7]) |=> (status[8] && status[7]));

    assert_chip_guard_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_chip_erase && (status[4:2] != 3'b000)) |=> reject);

    assert_busy_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (status[0] && !op_done && !power_cycle) |=> status[0]);

    assert_busy_reject_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (status[0] && any_cmd) |=> reject);

    assert_power_clear_R13: assert property (@(posedge clk) disable iff (!rst_n)
        power_cycle |=> (!status[0] && !status[1]));

endmodule

bind fsr_protect fsr_protect_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .cmd_wren       (cmd_wren),
    .cmd_wrdi       (cmd_wrdi),
    .cmd_wrsr       (cmd_wrsr),
    .cmd_prog       (cmd_prog),
    .cmd_erase      (cmd_erase),
    .cmd_chip_erase (cmd_chip_erase),
    .power_cycle    (power_cycle),
    .op_done        (op_done),
    .status         (status),
    .grant          (grant),
    .reject         (reject)
);

// File: tb/sim_fsr_protect.sv
`timescale 1ns/1ps
module sim_fsr_protect;

    localparam bit [5:0] C_NONE  = 6'd0;
    localparam bit [5:0] C_WREN  = 6'd1;
    localparam bit [5:0] C_WRDI  = 6'd2;
    localparam bit [5:0] C_WRSR  = 6'd4;
    localparam bit [5:0] C_PROG  = 6'd8;
    localparam bit [5:0] C_ERASE = 6'd16;
    localparam bit [5:0] C_CHIP  = 6'd32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  cmdv = '0;
    logic [15:0] wrsr_data = '0;
    logic        wp_n = 1'b1;
    logic        power_cycle = 1'b0;
    logic        op_done = 1'b0;
    logic [15:0] status;
    logic        grant;
    logic        reject;

    always #10 clk = ~clk;

    fsr_protect u0 (
        .clk            (clk),
        .rst_n          (rst_n),
        .cmd_wren       (cmdv[0]),
        .cmd_wrdi       (cmdv[1]),
        .cmd_wrsr       (cmdv[2]),
        .cmd_prog       (cmdv[3]),
        .cmd_erase      (cmdv[4]),
        .cmd_chip_erase (cmdv[5]),
        .wrsr_data      (wrsr_data),
        .wp_n           (wp_n),
        .power_cycle    (power_cycle),
        .op_done        (op_done),
        .status         (status),
        .grant          (grant),
        .reject         (reject)
    );

    int n_cmp  = 0;
    int n_bad  = 0;
    bit ended  = 0;
    string tag = "R1";

    // Behavioural reference state
    int m_wip, m_wel, m_bp, m_srp, m_qe, m_pend, m_pflag, m_grant, m_rej;

    function automatic int exp_status();
        return (m_qe << 9) | (m_srp << 7) | (m_bp << 2) | (m_wel << 1) | m_wip;
    endfunction

    task automatic model_step(input bit [5:0] c, input bit [15:0] d,
                              input bit pc, input bit dn);
        int n;
        int old_wip;
        bit ok;
        n = $countones(c);
        old_wip = m_wip;
        m_grant = 0;
        m_rej = 0;
        if (pc) begin
            if (n > 0) m_rej = 1;
            m_wel = 0; m_wip = 0; m_pflag = 0;
            if (m_srp == 2) m_srp = 0;
        end else begin
            if (old_wip == 1 && dn) begin
                if (m_pflag == 1) begin
                    m_bp  = (m_pend >> 2) & 31;
                    m_srp = (m_pend >> 7) & 3;
                    m_qe  = (m_pend >> 9) & 1;
                end
                m_wip = 0; m_wel = 0; m_pflag = 0;
            end
            if (n > 0) begin
                if (old_wip == 1 || n > 1) m_rej = 1;
                else if (c == C_WREN) begin m_wel = 1; m_grant = 1; end
                else if (c == C_WRDI) begin m_wel = 0; m_grant = 1; end
                else if (c == C_WRSR) begin
                    ok = (m_wel == 1) && (m_srp == 0 || (m_srp == 1 && wp_n));
                    if (ok) begin m_grant = 1; m_wip = 1; m_pend = d; m_pflag = 1; end
                    else m_rej = 1;
                end else if (c == C_PROG || c == C_ERASE) begin
                    if (m_wel == 1) begin m_grant = 1; m_wip = 1; m_pflag = 0; end
                    else m_rej = 1;
                end else begin
                    if (m_wel == 1 && (m_bp & 7) == 0) begin m_grant = 1; m_wip = 1; m_pflag = 0; end
                    else m_rej = 1;
                end
            end
        end
    endtask

    task automatic compare();
        n_cmp++;
        if (status !== 16'(exp_status()) || grant !== 1'(m_grant) || reject !== 1'(m_rej)) begin
            n_bad++;
            $display("FAIL %s t=%0t: status=%h grant=%b reject=%b expected status=%h grant=%0d reject=%0d",
                     tag, $time, status, grant, reject, 16'(exp_status()), m_grant, m_rej);
        end
    endtask

    // One clock: drive at negedge, model and compare after the posedge
    task automatic cyc(input bit [5:0] c, input bit [15:0] d, input bit pc, input bit dn);
        cmdv = c; wrsr_data = d; power_cycle = pc; op_done = dn;
        @(posedge clk);
        model_step(c, d, pc, dn);
        #2;
        compare();
        @(negedge clk);
        cmdv = '0; power_cycle = 1'b0; op_done = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(C_NONE, 16'h0, 0, 0);
    endtask

    task automatic fin();
        if (!ended) begin
            ended = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(20 * 20000);
        n_bad++;
        $display("FAIL watchdog: run did not complete, expected finish before timeout");
        fin();
    end

    initial begin
        m_wip = 0; m_wel = 0; m_bp = 0; m_srp = 0; m_qe = 0;
        m_pend = 0; m_pflag = 0; m_grant = 0; m_rej = 0;
        repeat (3) @(negedge clk);
        tag = "R1 reset";
        #1; compare();
        rst_n = 1'b1;
        idle(2);

        tag = "R5 no latch";
        cyc(C_WRSR, 16'h0200, 0, 0);
        cyc(C_PROG, 16'h0, 0, 0);
        cyc(C_ERASE, 16'h0, 0, 0);
        cyc(C_CHIP, 16'h0, 0, 0);
        idle(1);

        tag = "R4 latch";
        cyc(C_WREN, 16'h0, 0, 0);
        cyc(C_WRDI, 16'h0, 0, 0);
        cyc(C_WREN, 16'h0, 0, 0);

        tag = "R6 mode00 pin low, R2 reserved data";
        wp_n = 1'b0;
        cyc(C_WRSR, 16'hFE0F, 0, 0);
        tag = "R11 busy hold, R12 busy reject";
        cyc(C_WREN, 16'h0, 0, 0);
        cyc(C_WRDI, 16'h0, 0, 0);
        cyc(C_PROG, 16'h0, 0, 0);
        idle(1);
        tag = "R11 commit on done";
        cyc(C_NONE, 16'h0, 0, 1);
        idle(1);
        tag = "R11 done while idle";
        cyc(C_NONE, 16'h0, 0, 1);
        wp_n = 1'b1;

        tag = "R10 chip guard";
        cyc(C_WREN, 16'h0, 0, 0);
        cyc(C_CHIP, 16'h0, 0, 0);
        cyc(C_WRSR, 16'h0060, 0, 0);
        cyc(C_NONE, 16'h0, 0, 1);
        cyc(C_WREN, 16'h0, 0, 0);
        cyc(C_CHIP, 16'h0, 0, 0);
        idle(2);
        cyc(C_NONE, 16'h0, 0, 1);

        tag = "R11 program and erase";
        cyc(C_WREN, 16'h0, 0, 0);
        cyc(C_PROG, 16'h0, 0, 0);
        cyc(C_NONE, 16'h0, 0, 1);
        cyc(C_WREN, 16'h0, 0, 0);
        cyc(C_ERASE, 16'h0, 0, 0);
        cyc(C_NONE, 16'h0, 0, 1);

        tag = "R7 mode01";
        cyc(C_WREN, 16'h0, 0, 0);
        cyc(C_WRSR, 16'h0080, 0, 0);
        cyc(C_NONE, 16'h0, 0, 1);
        wp_n = 1'b0;
        cyc(C_WREN, 16'h0, 0, 0);
        cyc(C_WRSR, 16'h0000, 0, 0);
        wp_n = 1'b1;
        cyc(C_WRSR, 16'h0100, 0, 0);
        idle(1);
        cyc(C_NONE, 16'h0, 0, 1);

        tag = "R8 mode10";
        cyc(C_WREN, 16'h0, 0, 0);
        cyc(C_WRSR, 16'h0000, 0, 0);
        wp_n = 1'b0;
        cyc(C_WRSR, 16'h0000, 0, 0);
        wp_n = 1'b1;
        cyc(C_NONE, 16'h0, 1, 0);
        cyc(C_WREN, 16'h0, 0, 0);
        cyc(C_WRSR, 16'h0204, 0, 0);
        cyc(C_NONE, 16'h0, 0, 1);

        tag = "R13 power cycle";
        cyc(C_WREN, 16'h0, 0, 0);
        cyc(C_WRSR, 16'h03FC, 0, 0);
        idle(1);
        cyc(C_NONE, 16'h0, 1, 0);
        cyc(C_NONE, 16'h0, 0, 1);
        cyc(C_WREN, 16'h0, 1, 0);
        cyc(C_WREN, 16'h0, 0, 0);
        cyc(C_PROG, 16'h0, 0, 0);
        cyc(C_WREN, 16'h0, 1, 0);

        tag = "R14 multiple strobes";
        cyc(C_WREN | C_WRDI, 16'h0, 0, 0);
        cyc(C_WREN, 16'h0, 0, 0);
        cyc(C_WRDI | C_PROG, 16'h0, 0, 0);

        tag = "R3 quiet cycles";
        idle(2);

        tag = "R9 mode11";
        cyc(C_WRSR, 16'h0180, 0, 0);
        cyc(C_NONE, 16'h0, 0, 1);
        cyc(C_WREN, 16'h0, 0, 0);
        cyc(C_WRSR, 16'h0000, 0, 0);
        cyc(C_NONE, 16'h0, 1, 0);
        cyc(C_WREN, 16'h0, 0, 0);
        cyc(C_WRSR, 16'h0000, 0, 0);
        idle(2);

        fin();
    end

endmodule